// File: doc/BRIEF.md
# Display FIFO DMA Request Generator

This block sits between a memory-side DMA engine and a video display pipeline. It holds three pixel FIFOs of 64-bit doublewords: one for luma and one for each of the two colour-difference components. Each FIFO has its own event output. An event asks the DMA engine to deliver one block of doublewords into that FIFO, and it goes out when the FIFO has room for the whole block. The luma block size is programmed in doublewords. Each chroma block is half of it.

A per-field event budget limits how many requests each FIFO can raise. Software sets the budget to the field size divided by the luma block size. Each channel's counter reloads from that value when a field starts and counts down once per event. When a counter is exhausted, its channel goes quiet until the next field.

The display side pops doublewords through per-FIFO read strobes. If it pops an empty FIFO while display is active, a sticky underrun flag is set, and that flag drives an interrupt output under a mask.

Top module: `dfifo_req_gen`

## Requirements
- R1: After reset, all three event outputs are low, the underrun flag and the interrupt are low, and every FIFO is empty.
- R2: Each FIFO returns doublewords in the order written and holds DEPTH of them. A read strobe on an empty FIFO does not move it, and a write to a full FIFO is discarded.
- R3: A write to address 0 sets the luma block size in doublewords. The luma event (bit 0 of `dma_evt`) pulses high for exactly one cycle. It rises on the clock edge after the edge at which all of these hold: free space is at least the block size, no luma block is outstanding, and the channel's event budget is nonzero.
- R4: Both chroma channels (bit 1 and bit 2 of `dma_evt`) use a block size of floor(luma block / 2). A chroma block size of zero never raises an event.
- R5: After an event, its channel raises no further event until exactly one block size of doublewords has been accepted into that FIFO.
- R6: A write to address 1 sets the event budget. Each channel loads the budget on a `field_start` cycle, raises no event in that cycle, and decrements the budget on each event. When the FIFOs start empty and nothing reads them, a field gives min(budget, floor(DEPTH / block)) events per channel.
- R7: A write to address 1 during a field does not change the current field's remaining budget. It takes effect at the next `field_start`.
- R8: A read strobe on an empty FIFO while `disp_active` is high sets `urun_sts`, which stays set until cleared. The same strobe with `disp_active` low leaves it clear.
- R9: Writing address 2 with bit 0 sets the interrupt enable, and `urun_irq` equals `urun_sts` while the enable is set. Writing address 2 with bit 1 set clears `urun_sts`.
- R10: A luma block size of zero, or one larger than DEPTH, raises no luma event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address (0 block size, 1 budget, 2 interrupt control) |
| cfg_wdata | input | CFG_W | Configuration write data |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| disp_active | input | 1 | High while the display is consuming pixels |
| dma_wr_en | input | 3 | Per-FIFO write strobe from DMA (bit 0 luma, 1 blue-diff, 2 red-diff) |
| dma_wr_data | input | 3*DW | Per-FIFO write data, one DW slice per FIFO |
| pix_rd_en | input | 3 | Per-FIFO read strobe from the display |
| pix_rd_data | output | 3*DW | Per-FIFO head data (show-ahead) |
| dma_evt | output | 3 | Per-FIFO DMA request pulse |
| urun_sts | output | 1 | Sticky underrun status |
| urun_irq | output | 1 | Masked underrun interrupt |

## Verification
The bench sweeps every block size from 0 up to one past DEPTH against budgets 0 to 3. A DMA model answers each event with exactly one block of writes. The resulting event counts show whether the field was limited by FIFO space or by the budget. Odd block sizes check that chroma rounds down. Sizes of 0 and DEPTH+1 check that an impossible request stays silent. Each field's first event is checked at its exact cycle to pin down the latency. After each field the bench drains every FIFO and checks the data order. A budget rewrite in the middle of a field must leave that field untouched and take hold only at the next field start. Empty reads with display active and with it inactive separate a real underrun from an idle read. The mask and clear writes are then applied to the sticky flag.

// File: rtl/dfrg_pkg.sv
package dfrg_pkg;
  localparam int NCH = 3;

  // chroma blocks carry half the doublewords of a luma block
  function automatic int unsigned half_blk(int unsigned blk);
    return blk >> 1;
  endfunction

  // a block may be requested only if it is nonzero and fits the free space
  function automatic logic room_ok(int unsigned lvl, int unsigned blk,
                                   int unsigned depth);
    return (blk != 0) && (lvl <= depth) && ((depth - lvl) >= blk);
  endfunction
endpackage

// File: rtl/dfrg_fifo.sv
module dfrg_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          wr_acc
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, rd_acc;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign wr_acc  = wr_en && !full;
  assign rd_acc  = rd_en && !empty;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_acc) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_acc) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({wr_acc, rd_acc})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en |=> level == LW'(DEPTH));
  p_empty_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_en && !wr_en |=> level == '0);
endmodule

// File: rtl/dfrg_chan.sv
module dfrg_chan #(
  parameter int DEPTH = 8,
  parameter int CW    = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_start,
  input  logic [CW-1:0] blk,
  input  logic [CW-1:0] cnt_prog,
  input  logic [LW-1:0] level,
  input  logic          wr_acc,
  output logic          evt
);
  logic          busy_q;
  logic [CW-1:0] remain_q;
  logic [CW-1:0] cnt_q;
  logic          fire;

  assign fire = !field_start && !busy_q && (cnt_q != '0) &&
                dfrg_pkg::room_ok(32'(level), 32'(blk), DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt      <= 1'b0;
      busy_q   <= 1'b0;
      remain_q <= '0;
      cnt_q    <= '0;
    end else begin
      evt <= fire;
      if (field_start)  cnt_q <= cnt_prog;
      else if (fire)    cnt_q <= cnt_q - 1'b1;
      if (fire) begin
        busy_q   <= 1'b1;
        remain_q <= blk;
      end else if (busy_q && wr_acc) begin
        remain_q <= remain_q - 1'b1;
        if (remain_q == CW'(1)) busy_q <= 1'b0;
      end
    end
  end

  p_evt_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  p_evt_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> busy_q);
  p_cnt_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(cnt_q) != '0);
  p_fs_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> cnt_q == $past(cnt_prog));
endmodule

// File: rtl/dfifo_req_gen.sv
module dfifo_req_gen #(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  parameter int CFG_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [1:0]                        cfg_addr,
  input  logic [CFG_W-1:0]                  cfg_wdata,
  input  logic                              field_start,
  input  logic                              disp_active,
  input  logic [dfrg_pkg::NCH-1:0]          dma_wr_en,
  input  logic [dfrg_pkg::NCH*DW-1:0]       dma_wr_data,
  input  logic [dfrg_pkg::NCH-1:0]          pix_rd_en,
  output logic [dfrg_pkg::NCH*DW-1:0]       pix_rd_data,
  output logic [dfrg_pkg::NCH-1:0]          dma_evt,
  output logic                              urun_sts,
  output logic                              urun_irq
);
  localparam int NCH = dfrg_pkg::NCH;
  localparam int LW  = $clog2(DEPTH + 1);

  logic [CFG_W-1:0] thr_q, cnt_prog_q;
  logic             irq_en_q;
  logic             urun_clr, urun_evt;
  logic [NCH-1:0]   ch_empty, ch_wr_acc;
  logic [LW-1:0]    ch_level [NCH];
  logic [CFG_W-1:0] ch_blk   [NCH];

  assign urun_clr = cfg_we && (cfg_addr == 2'd2) && cfg_wdata[1];
  assign urun_evt = disp_active && |(pix_rd_en & ch_empty);
  assign urun_irq = urun_sts && irq_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q      <= '0;
      cnt_prog_q <= '0;
      irq_en_q   <= 1'b0;
      urun_sts   <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          2'd0:    thr_q      <= cfg_wdata;
          2'd1:    cnt_prog_q <= cfg_wdata;
          2'd2:    irq_en_q   <= cfg_wdata[0];
          default: ;
        endcase
      end
      if (urun_evt)      urun_sts <= 1'b1;
      else if (urun_clr) urun_sts <= 1'b0;
    end
  end

  p_urun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    urun_sts && !urun_clr |=> urun_sts);
  p_urun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    urun_evt |=> urun_sts);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g == 0) begin : g_luma
      assign ch_blk[g] = thr_q;
    end else begin : g_chroma
      assign ch_blk[g] = CFG_W'(dfrg_pkg::half_blk(32'(thr_q)));
    end

    dfrg_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dma_wr_en[g]),
      .wr_data (dma_wr_data[g*DW +: DW]),
      .rd_en   (pix_rd_en[g]),
      .rd_data (pix_rd_data[g*DW +: DW]),
      .level   (ch_level[g]),
      .empty   (ch_empty[g]),
      .wr_acc  (ch_wr_acc[g])
    );

    dfrg_chan #(.DEPTH(DEPTH), .CW(CFG_W), .LW(LW)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .field_start (field_start),
      .blk         (ch_blk[g]),
      .cnt_prog    (cnt_prog_q),
      .level       (ch_level[g]),
      .wr_acc      (ch_wr_acc[g]),
      .evt         (dma_evt[g])
    );
  end
endmodule

// File: tb/dfifo_req_gen_test.sv
module dfifo_req_gen_test;
  localparam int DW = 64;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic field_start = 1'b0;
  logic disp_active = 1'b0;
  logic [2:0] dma_wr_en = '0;
  logic [3*DW-1:0] dma_wr_data = '0;
  logic [2:0] pix_rd_en = '0;
  logic [3*DW-1:0] pix_rd_data;
  logic [2:0] dma_evt;
  logic urun_sts, urun_irq;

  int nchk = 0, nfail = 0;
  int wseq[3], rseq[3], evc[3];

  always #5 clk = ~clk;

  dfifo_req_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .field_start(field_start), .disp_active(disp_active),
    .dma_wr_en(dma_wr_en), .dma_wr_data(dma_wr_data), .pix_rd_en(pix_rd_en),
    .pix_rd_data(pix_rd_data), .dma_evt(dma_evt), .urun_sts(urun_sts),
    .urun_irq(urun_irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  function automatic int blk_of(int c, int thr);
    return (c == 0) ? thr : thr / 2;
  endfunction

  function automatic int exp_events(int b, int cnt);
    int room;
    if (b == 0 || b > DEPTH) return 0;
    room = DEPTH / b;
    return (cnt < room) ? cnt : room;
  endfunction

  function automatic logic [63:0] word(int c, int s);
    return {32'(c), 32'(s)};
  endfunction

  task automatic cfg_write(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_field();
    @(negedge clk);
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  // DMA model: answer every event with one block of writes
  task automatic run_field(input int thr, input int cycles, input logic chk_first,
                           input logic [2:0] exp_first);
    int pend[3];
    for (int c = 0; c < 3; c++) begin pend[c] = 0; evc[c] = 0; end
    for (int cyc = 0; cyc < cycles; cyc++) begin
      @(negedge clk);
      if (cyc == 0 && chk_first) chk("R3 first event one cycle after load", 64'(dma_evt), 64'(exp_first));
      for (int c = 0; c < 3; c++) begin
        if (dma_evt[c]) begin pend[c] += blk_of(c, thr); evc[c]++; end
        if (pend[c] > 0) begin
          dma_wr_en[c] = 1'b1;
          dma_wr_data[c*DW +: DW] = word(c, wseq[c]);
          wseq[c]++;
          pend[c]--;
        end else dma_wr_en[c] = 1'b0;
      end
    end
    @(negedge clk);
    dma_wr_en = '0;
  endtask

  task automatic drain();
    int maxw = 0;
    for (int c = 0; c < 3; c++) if (wseq[c] - rseq[c] > maxw) maxw = wseq[c] - rseq[c];
    for (int i = 0; i < maxw; i++) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
        if (rseq[c] < wseq[c]) begin
          chk("R2 fifo order", pix_rd_data[c*DW +: DW], word(c, rseq[c]));
          pix_rd_en[c] = 1'b1;
          rseq[c]++;
        end else pix_rd_en[c] = 1'b0;
      end
    end
    @(negedge clk);
    pix_rd_en = '0;
  endtask

  task automatic zero_field();
    cfg_write(1, 0);
    pulse_field();
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++) begin wseq[c] = 0; rseq[c] = 0; evc[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 events idle", 64'(dma_evt), 64'd0);
    chk("R1 underrun clear", 64'(urun_sts), 64'd0);
    chk("R1 irq clear", 64'(urun_irq), 64'd0);

    // R3 R4 R6 R10 sweep over block size and budget
    for (int thr = 0; thr <= DEPTH + 1; thr++) begin
      for (int cnt = 0; cnt <= 3; cnt++) begin
        logic [2:0] ef;
        cfg_write(0, thr);
        cfg_write(1, cnt);
        pulse_field();
        chk("R6 no event in load cycle", 64'(dma_evt), 64'd0);
        for (int c = 0; c < 3; c++) ef[c] = (exp_events(blk_of(c, thr), cnt) > 0);
        run_field(thr, 60, 1'b1, ef);
        for (int c = 0; c < 3; c++)
          chk((c == 0) ? "R3 R6 R10 luma event count" : "R4 R6 chroma event count",
              64'(evc[c]), 64'(exp_events(blk_of(c, thr), cnt)));
        zero_field();
      end
    end

    // R5 R7: mid-field budget rewrite takes effect only at next field
    cfg_write(0, 2);
    cfg_write(1, 1);
    pulse_field();
    run_field(2, 20, 1'b0, 3'b000);
    for (int c = 0; c < 3; c++) chk("R5 one block per event", 64'(evc[c]), 64'd1);
    cfg_write(1, 3);
    run_field(2, 20, 1'b0, 3'b000);
    for (int c = 0; c < 3; c++) chk("R7 mid-field write ignored", 64'(evc[c]), 64'd0);
    pulse_field();
    run_field(2, 40, 1'b0, 3'b000);
    for (int c = 0; c < 3; c++) chk("R7 new budget at next field", 64'(evc[c]), 64'd3);
    zero_field();

    // R2 R8: empty reads while inactive move nothing and flag nothing
    @(negedge clk);
    pix_rd_en = 3'b111;
    @(negedge clk);
    pix_rd_en = '0;
    chk("R8 inactive empty read", 64'(urun_sts), 64'd0);
    for (int c = 0; c < 3; c++) begin
      dma_wr_en[c] = 1'b1;
      dma_wr_data[c*DW +: DW] = word(c, wseq[c]);
      wseq[c]++;
    end
    @(negedge clk);
    dma_wr_en = '0;
    drain();

    // R8 R9 underrun and mask
    @(negedge clk);
    disp_active = 1'b1;
    pix_rd_en = 3'b010;
    @(negedge clk);
    pix_rd_en = '0;
    disp_active = 1'b0;
    chk("R8 underrun set", 64'(urun_sts), 64'd1);
    chk("R9 irq masked", 64'(urun_irq), 64'd0);
    cfg_write(2, 1);
    chk("R9 irq enabled", 64'(urun_irq), 64'd1);
    repeat (3) @(negedge clk);
    chk("R8 underrun sticky", 64'(urun_sts), 64'd1);
    cfg_write(2, 3);
    chk("R9 underrun cleared", 64'(urun_sts), 64'd0);
    chk("R9 irq cleared", 64'(urun_irq), 64'd0);

    report();
    $finish;
  end
endmodule